// File: doc/BRIEF.md
# Page-mode pseudo-SRAM controller

This block sits on the host side of an asynchronous pseudo-SRAM and converts requests from a simple synchronous valid/ready port into the chip strobes. The strobes are an active-low chip enable, write enable and output enable, plus one active-low enable for each byte lane. A read request carries a start address, a word count minus one and a lane mask. A write request carries one address, one data word and a lane mask. Every timing interval is a whole number of system-clock cycles. The cycle counts are derived at elaboration from nanosecond parameters and the clock period, with each minimum rounded up.

A read burst opens with a full random access. Words that follow in the same aligned group of eight are fetched as fast page accesses: chip enable stays low and only address bits 2..0 move. The burst closes the page and starts a new random access after a short chip-enable-high gap in two cases. The first is when the next word crosses into another group. The second is when one more page access would push the continuous chip-enable-low time past its budget. Each read word is sampled on the clock edge where its access count runs out, and it is handed back with a one-cycle `rd_valid` pulse.

The controller is a six-state machine. `ST_IDLE` accepts a request. A read goes from there to `ST_RD_FIRST`, and a write goes to `ST_WR_PULSE`. When its count expires, `ST_RD_FIRST` moves to `ST_RD_PAGE` if the next word stays on the page, or to `ST_CE_GAP` if it does not. `ST_RD_PAGE` makes the same choice each time it completes. `ST_WR_PULSE` moves to `ST_WR_RECOV`, and that state moves to `ST_CE_GAP`. `ST_CE_GAP` goes to `ST_RD_FIRST` when words of a split burst remain, and to `ST_IDLE` otherwise.

Top module: `psram_page_ctrl`

## Requirements
- R1: During and after reset, with no request, all five strobes are high (inactive), `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A random read holds chip enable and output enable low and write enable high for RC cycles (RC = ceil(85 ns / clock period), 5 at 20 ns). The accept edge is edge A. The word is sampled at edge A+RC, and `rd_valid` is high for exactly the cycle that follows that edge.
- R3: Inside a burst, a word whose predecessor is not at offset 7 of its 8-word group is fetched as a page access. Chip enable stays low, address bits 20..3 do not change, and the word arrives PC cycles after the previous one (PC = ceil(30 ns / period), 2 at 20 ns).
- R4: When the previous word sits at offset 7 of its group, chip enable goes high for CEH cycles (ceil(15 ns / period), 1 at 20 ns). A new random access then follows, so that word arrives CEH+RC cycles after the previous one.
- R5: Chip enable is never low for more than CEMAX consecutive cycles (floor(budget ns / period)). A page access that would exceed this is replaced by the gap and a random access of R4.
- R6: Every falling edge of chip enable comes after at least CEH cycles with it high.
- R7: A write drives write enable low for WP cycles. WP is the largest of ceil(50 ns / period), ceil(20 ns / period) and the write-cycle count minus WR, which gives 4 at 20 ns. Write enable is then high for WR cycles (ceil(15 ns / period), 1) while chip enable stays low. Output enable is high for the whole write, and data is driven during both phases.
- R8: Lane mask bit 0 selects the lower lane, data bits 7..0, and drives `mem_lb_n` low. Bit 1 selects the upper lane, bits 15..8, and drives `mem_ub_n` low. Both bits set means a word access. A write changes only the selected lanes. A read returns the full bus, with deselected lanes carrying whatever the memory drives.
- R9: `req_ready` is high only in `ST_IDLE`, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. A write's word count is ignored: exactly one write pulse is issued.
- R10: A read with count field N returns exactly N+1 `rd_valid` pulses, carrying the words at consecutive ascending addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (21) | Word address of the first transfer |
| req_len | input | LW (5) | Read word count minus one; ignored for writes |
| req_be | input | 2 | Lane mask: bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | DW (16) | Write data |
| rd_valid | output | 1 | One-cycle pulse marking a returned read word |
| rd_data | output | DW (16) | Returned read word |
| mem_addr | output | AW (21) | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte lane enable, active low |
| mem_ub_n | output | 1 | Upper byte lane enable, active low |
| mem_dq_out | output | DW (16) | Data driven towards the memory |
| mem_dq_oe | output | 1 | High while `mem_dq_out` should drive the bus |
| mem_dq_in | input | DW (16) | Data returned by the memory |

## Verification
A wrong cycle count or a wrong capture edge in a read shows up at the first `rd_valid` of that burst: the pulse comes at the wrong edge, or the word is the poison value the bench memory returns before its access time has passed. A wrong page or budget decision shows up one word later, as the wrong spacing between pulses. It also shows up as a chip-enable-low run that is too long, or as upper address bits moving while chip enable is low. A fault in the write path shows up within one write cycle as a wrong pulse length, a lane change or output enable low. It shows up again on the next readback of that address.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_PAGE,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_CE_GAP
    } pc_state_t;

    // Round a nanosecond minimum up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/psram_page_guard.sv
module psram_page_guard #(
    parameter int PAGE_CYC  = 2,
    parameter int LIMIT_CYC = 200,
    parameter int PAGE_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_low,
    input  logic [PAGE_BITS-1:0] word_in_page,
    output logic                 stay_ok
);
    localparam int CW = $clog2(LIMIT_CYC + 1) + 1;
    localparam logic [CW-1:0] SAT = LIMIT_CYC[CW-1:0];

    // Cycles chip enable has been low in the current window (0 in its first cycle)
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt <= '0;
        else if (!ce_low)        low_cnt <= '0;
        else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
    end

    // Another page access fits if the page does not end here and the window
    // including that access stays within the budget
    assign stay_ok = !(&word_in_page) &&
                     ((int'(low_cnt) + 1 + PAGE_CYC) <= LIMIT_CYC);
endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
    import psram_pkg::*;
#(
    parameter int AW         = 21,
    parameter int DW         = 16,
    parameter int LW         = 5,
    parameter int PAGE_WORDS = 8,
    parameter int CLK_NS     = 20,
    parameter int T_RC_NS    = 85,
    parameter int T_PC_NS    = 30,
    parameter int T_PAA_NS   = 25,
    parameter int T_CEH_NS   = 15,
    parameter int T_WC_NS    = 85,
    parameter int T_WP_NS    = 50,
    parameter int T_WR_NS    = 15,
    parameter int T_DS_NS    = 20,
    parameter int CE_MAX_NS  = 4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [1:0]    req_be,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int PAGE_BITS = $clog2(PAGE_WORDS);
    localparam int RC_CYC    = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int PC_CYC    = max2(ns_to_cyc(T_PC_NS, CLK_NS), ns_to_cyc(T_PAA_NS, CLK_NS));
    localparam int CEH_CYC   = ns_to_cyc(T_CEH_NS, CLK_NS);
    localparam int WR_CYC    = ns_to_cyc(T_WR_NS, CLK_NS);
    localparam int WP_CYC    = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                                    ns_to_cyc(T_WC_NS, CLK_NS) - WR_CYC);
    localparam int CEMAX_CYC = CE_MAX_NS / CLK_NS;
    localparam int LONGEST   = max2(max2(RC_CYC, WP_CYC), max2(PC_CYC, max2(CEH_CYC, WR_CYC)));
    localparam int TW        = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] RC_LD  = TW'(RC_CYC - 1);
    localparam logic [TW-1:0] PC_LD  = TW'(PC_CYC - 1);
    localparam logic [TW-1:0] CEH_LD = TW'(CEH_CYC - 1);
    localparam logic [TW-1:0] WP_LD  = TW'(WP_CYC - 1);
    localparam logic [TW-1:0] WR_LD  = TW'(WR_CYC - 1);

    pc_state_t     state, nstate;
    logic          tmr_load, tmr_done, stay_ok, capture;
    logic [TW-1:0] tmr_val;
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] words_left;
    logic [1:0]    be_q;
    logic [DW-1:0] wdata_q;
    logic          more_q;
    logic          active;

    psram_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    psram_page_guard #(.PAGE_CYC(PC_CYC), .LIMIT_CYC(CEMAX_CYC), .PAGE_BITS(PAGE_BITS)) u_guard (
        .clk(clk), .rst_n(rst_n), .ce_low(!mem_ce_n),
        .word_in_page(cur_addr[PAGE_BITS-1:0]), .stay_ok(stay_ok)
    );

    assign capture = ((state == ST_RD_FIRST) || (state == ST_RD_PAGE)) && tmr_done;

    // Next state and timer loads
    always_comb begin
        nstate   = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) begin nstate = ST_WR_PULSE; tmr_val = WP_LD; end
                else           begin nstate = ST_RD_FIRST; tmr_val = RC_LD; end
            end
            ST_RD_FIRST, ST_RD_PAGE: if (tmr_done) begin
                tmr_load = 1'b1;
                if (words_left != '0 && stay_ok) begin nstate = ST_RD_PAGE; tmr_val = PC_LD;  end
                else                             begin nstate = ST_CE_GAP;  tmr_val = CEH_LD; end
            end
            ST_WR_PULSE: if (tmr_done) begin
                nstate = ST_WR_RECOV; tmr_load = 1'b1; tmr_val = WR_LD;
            end
            ST_WR_RECOV: if (tmr_done) begin
                nstate = ST_CE_GAP; tmr_load = 1'b1; tmr_val = CEH_LD;
            end
            ST_CE_GAP: if (tmr_done) begin
                if (more_q) begin nstate = ST_RD_FIRST; tmr_load = 1'b1; tmr_val = RC_LD; end
                else              nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Request capture, burst progress and read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            words_left <= '0;
            be_q       <= '0;
            wdata_q    <= '0;
            more_q     <= 1'b0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (state == ST_IDLE && req_valid) begin
                cur_addr   <= req_addr;
                words_left <= req_write ? '0 : req_len;
                be_q       <= req_be;
                wdata_q    <= req_wdata;
                more_q     <= 1'b0;
            end
            if (capture) begin
                rd_data  <= mem_dq_in;
                rd_valid <= 1'b1;
                more_q   <= (words_left != '0);
                if (words_left != '0) begin
                    cur_addr   <= cur_addr + 1'b1;
                    words_left <= words_left - 1'b1;
                end
            end
        end
    end

    // Strobes from state
    always_comb begin
        active     = 1'b0;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        unique case (state)
            ST_RD_FIRST, ST_RD_PAGE: begin active = 1'b1; mem_oe_n = 1'b0; end
            ST_WR_PULSE: begin active = 1'b1; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_RECOV: begin active = 1'b1; mem_dq_oe = 1'b1; end
            ST_IDLE, ST_CE_GAP: active = 1'b0;
            default: active = 1'b0;
        endcase
        mem_ce_n   = !active;
        mem_lb_n   = !(active && be_q[0]);
        mem_ub_n   = !(active && be_q[1]);
        mem_addr   = cur_addr;
        mem_dq_out = wdata_q;
        req_ready  = (state == ST_IDLE);
    end
endmodule

// File: rtl/psram_page_chk.sv
module psram_page_chk #(
    parameter int AW    = 21,
    parameter int CEH   = 1,
    parameter int CEMAX = 200
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rd_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_lb_n,
    input logic          mem_ub_n,
    input logic          mem_dq_oe
);
    localparam int CW = $clog2(CEMAX + CEH + 2) + 1;
    localparam logic [CW-1:0] HI_SAT = CW'(CEH);
    localparam logic [CW-1:0] LO_SAT = CW'(CEMAX + 1);

    logic [CW-1:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HI_SAT;
            lo_cnt <= '0;
        end else begin
            if (mem_ce_n) begin
                lo_cnt <= '0;
                if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != LO_SAT) lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end

    a_r7_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

    a_r3_upper_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[AW-1:3] == $past(mem_addr[AW-1:3])));

    a_r6_ce_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (hi_cnt >= HI_SAT));

    a_r5_ce_low_budget: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (int'(lo_cnt) < CEMAX));

    a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_ce_n && !mem_oe_n && mem_we_n));

    a_r8_lanes_follow_ce: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_lb_n && mem_ub_n));
endmodule

bind psram_page_ctrl psram_page_chk #(.AW(AW), .CEH(CEH_CYC), .CEMAX(CEMAX_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_psram_page_ctrl.sv
module sim_psram_page_ctrl;
    localparam int RC = 5, PC = 2, CEH = 1, WP = 4, WR = 1, CEMAX = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [4:0]  req_len = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic [20:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int checks = 0, errors = 0, cyc = 0;

    always #10 clk = ~clk;

    psram_page_ctrl #(.CE_MAX_NS(200)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model with access-time poisoning, and the bench's own shadow copy
    logic [15:0] mdl [0:255];
    logic [15:0] sh  [0:255];
    int          ce_cnt = 0, pcnt = 0;
    logic [20:0] last_addr = '0;
    logic        rd_ok;

    function automatic logic [15:0] seed_word(input int i);
        return 16'(i * 32'h9E37) ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            mdl[i] = seed_word(i);
            sh[i]  = seed_word(i);
        end
    end

    always @(posedge clk) begin
        ce_cnt    <= mem_ce_n ? 0 : ce_cnt + 1;
        pcnt      <= (mem_addr != last_addr) ? 1 : pcnt + 1;
        last_addr <= mem_addr;
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    assign rd_ok = !mem_ce_n && !mem_oe_n && mem_we_n && (ce_cnt >= RC - 1) &&
                   (mem_addr == last_addr) && (pcnt >= PC - 1);
    assign mem_dq_in = !rd_ok ? 16'hDEAD :
                       {mem_ub_n ? 8'h00 : mdl[mem_addr[7:0]][15:8],
                        mem_lb_n ? 8'h00 : mdl[mem_addr[7:0]][7:0]};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Port monitors for the page rules and the chip-enable-low budget
    int          lowrun = 0;
    logic        prev_ce_n = 1'b1;
    logic [20:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && !prev_ce_n && mem_addr[20:3] != prev_addr[20:3])
                chk(1'b0, "R3 upper address moved under low chip enable", 32'(mem_addr), 32'(prev_addr));
            lowrun = mem_ce_n ? 0 : lowrun + 1;
            if (lowrun > CEMAX) chk(1'b0, "R5 chip enable low too long", lowrun, CEMAX);
        end
        prev_ce_n = mem_ce_n;
        prev_addr = mem_addr;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_idle();
        for (int t = 0; t < 100 && !req_ready; t++) @(negedge clk);
    endtask

    task automatic do_read(input logic [20:0] addr, input int len, input logic [1:0] be);
        int k = 1, got = 0, exp_at = RC + 1, low = RC;
        logic [20:0] a = addr;
        string why = "R2 first word timing";
        wait_idle();
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr; req_len = 5'(len); req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
        while (got <= len && k < 300) begin
            if (rd_valid) begin
                chk(k == exp_at, why, k, exp_at);
                chk(rd_data == (sh[a[7:0]] & lane_mask(be)), "R10 burst data / R8 lanes",
                    rd_data, sh[a[7:0]] & lane_mask(be));
                got++;
                if (a[2:0] != 3'd7 && low + PC <= CEMAX) begin
                    exp_at = k + PC; low += PC; why = "R3 page word timing";
                end else begin
                    exp_at = k + CEH + RC; low = RC;
                    why = (a[2:0] == 3'd7) ? "R4 page boundary split" : "R5 budget split";
                end
                a = a + 1'b1;
            end
            @(negedge clk);
            k++;
        end
        chk(got == len + 1, "R10 word count", got, len + 1);
    endtask

    task automatic do_write(input logic [20:0] addr, input logic [15:0] data,
                            input logic [1:0] be, input int len);
        int nwe = 0, nrec = 0, extra = 0;
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_len = 5'(len);
        req_be = be; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
        chk({mem_ub_n, mem_lb_n} == ~be, "R8 lane enables on write", {mem_ub_n, mem_lb_n}, ~be);
        chk(mem_dq_out == data && mem_dq_oe, "R7 write data driven", mem_dq_out, data);
        while (!mem_we_n && nwe < 20) begin
            if (!mem_oe_n) chk(1'b0, "R7 output enable low in write", mem_oe_n, 1);
            nwe++; @(negedge clk);
        end
        while (mem_we_n && !mem_ce_n && nrec < 20) begin
            if (!mem_dq_oe) chk(1'b0, "R7 data released in recovery", mem_dq_oe, 1);
            nrec++; @(negedge clk);
        end
        chk(nwe == WP, "R7 write pulse cycles", nwe, WP);
        chk(nrec == WR, "R7 write recovery cycles", nrec, WR);
        for (int t = 0; t < 20 && !req_ready; t++) begin
            if (!mem_we_n) extra++;
            @(negedge clk);
        end
        chk(extra == 0, "R9 write count ignored", extra, 0);
        if (be[0]) sh[addr[7:0]][7:0]  = data[7:0];
        if (be[1]) sh[addr[7:0]][15:8] = data[15:8];
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 strobes in reset",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rd_valid && !mem_dq_oe && mem_ce_n && mem_oe_n && mem_we_n,
            "R1 idle after reset", {req_ready, rd_valid, mem_dq_oe, mem_ce_n}, 4'b1001);

        do_read(21'h13, 0, 2'b11);          // R2 single random read
        do_read(21'h20, 2, 2'b11);          // R3 page burst inside a group
        do_read(21'h25, 5, 2'b11);          // R4 crossing an 8-word boundary
        do_read(21'h40, 7, 2'b11);          // R5 budget forces a split
        do_write(21'h13, 16'hBEEF, 2'b11, 0);
        do_read(21'h13, 0, 2'b11);          // R7 readback
        do_write(21'h50, 16'h1234, 2'b01, 0);
        do_write(21'h50, 16'h5678, 2'b10, 0);
        do_read(21'h50, 0, 2'b11);          // R8 lanes merged: 5634
        do_read(21'h50, 0, 2'b10);          // R8 upper lane read
        do_write(21'h60, 16'hA5A5, 2'b11, 5);
        do_read(21'h60, 1, 2'b11);          // R9 neighbour untouched
        do_read(21'h1FFFFB, 9, 2'b01);      // R4 boundary near top of space

        for (int n = 0; n < 40; n++) begin
            logic [20:0] ra = 21'($urandom);
            logic [1:0]  rb = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 2) == 0) do_write(ra, 16'($urandom), rb, $urandom_range(0, 3));
            else                           do_read(ra, $urandom_range(0, 12), rb);
        end

        wait_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule